// File: doc/BRIEF.md
# Strap-Captured Shared Clock Pins

The block controls three shared pins. Each pin can carry either a configuration input or one of three optional low-voltage clock outputs. A static mode input selects the role of the pins. When the mode input is low, the pins are ordinary inputs: frequency select A, frequency select B and an active-low spread-spectrum enable. Each pin passes through a two-flop synchronizer before it reaches the configuration outputs.

When the mode input is high, the pins act as straps. Their levels are captured once, on the first clock edge after the power-on reset is released, and held until the next power-on reset. From then on the held values drive the configuration outputs. One cycle after the capture, the pad output enables turn on and the pins drive a divided clock. That clock is nominally 33.33 MHz when `clk_i` is 133.33 MHz and `CLK_DIV` is 4.

A power-down request stops the clock outputs in the low state. A high phase that has already started always runs to its end, so no short pulse appears on a pin. When the request is released, the clock starts again. A power-down request never causes the straps to be captured again. Only `rst_ni` does that.

Top module: `strap_pin_ctrl`

## Requirements
- R1: While `rst_ni` is low, `pad_oe_o` and `pad_out_o` are all zero.
- R2: While `mode_i` is low, `pad_oe_o` is zero at all times.
- R3: With `mode_i` low, `sel_a_o` follows `pad_in_i[0]`, `sel_b_o` follows `pad_in_i[1]`, and `spread_en_o` follows the inverse of `pad_in_i[2]`. Each follows its pin through exactly two rising edges of `clk_i`.
- R4: With `mode_i` high, the configuration outputs hold the pad values sampled on the first rising edge after `rst_ni` is released. The bit mapping is the same as in R3. Later changes on `pad_in_i` have no effect on them.
- R5: With `mode_i` high, `pad_oe_o` is zero after the first rising edge following reset release and is 3'b111 after the second.
- R6: While enabled and not powered down, every bit of `pad_out_o` is a clock with period `CLK_DIV` cycles of `clk_i`, high for `CLK_DIV/2` and low for `CLK_DIV/2`.
- R7: When `pwrdn_ni` is low, the clock outputs stop low. A high phase in progress completes, so every high phase lasts exactly `CLK_DIV/2` cycles. When `pwrdn_ni` is released, the clock resumes.
- R8: Asserting and then releasing `pwrdn_ni` does not capture the pads again. The configuration outputs keep the values captured at power-on.
- R9: `pad_out_o` is high only on pins whose output enable is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock for synchronizers and the clock divider |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mode_i | input | 1 | Pin role: 0 selects live inputs, 1 selects strap capture plus clock outputs |
| pwrdn_ni | input | 1 | Asynchronous active-low power-down request |
| pad_in_i | input | 3 | Pad input levels; bit 0 select A, bit 1 select B, bit 2 spread enable (active low) |
| pad_out_o | output | 3 | Pad output drive (divided clock) |
| pad_oe_o | output | 3 | Pad output enables |
| sel_a_o | output | 1 | Frequency select A |
| sel_b_o | output | 1 | Frequency select B |
| spread_en_o | output | 1 | Spread-spectrum enable, active high |

## Verification
The assertions assume that `mode_i` is a board strap and stays constant from the time `rst_ni` is released until the next reset. The bench therefore sets `mode_i` only while reset is held. The high-phase and low-phase length checks also assume that `pwrdn_ni` is synchronous enough to pass through its synchronizer. The bench changes `pwrdn_ni` and `pad_in_i` only on falling edges, well clear of the capture edges. It sweeps all eight pad patterns in both modes and reapplies a full reset for each pattern.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned NPINS = 3;
  localparam int unsigned PIN_SEL_A = 0;
  localparam int unsigned PIN_SEL_B = 1;
  localparam int unsigned PIN_SS_N  = 2;
  typedef logic [NPINS-1:0] pin_vec_t;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL;
        sync_q <= RST_VAL;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_i,
  input  pin_vec_t pad_in_i,
  output pin_vec_t held_o,
  output logic     drv_en_o
);
  logic     cap_done_q;
  logic     oe_q;
  pin_vec_t held_q;

  // one-shot capture: only a power-on reset re-arms it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_done_q <= 1'b0;
      held_q     <= '0;
    end else if (!cap_done_q) begin
      cap_done_q <= 1'b1;
      held_q     <= pad_in_i;
    end
  end

  // driver turns on one cycle after the sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= cap_done_q & mode_i;
  end

  assign held_o   = held_q;
  assign drv_en_o = oe_q & mode_i;

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_done_q |=> $stable(held_q));
  assert_oe_after_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(cap_done_q));
  assert_capture_once_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cap_done_q) |-> cap_done_q);
endmodule

// File: rtl/strap_clk_div.sv
module strap_clk_div #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);
  localparam int unsigned HALF  = CLK_DIV / 2;
  localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned LEN_W = $clog2(CLK_DIV + 2) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             clk_q;
  logic             at_edge;

  assign at_edge = (cnt_q == CNT_W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (at_edge) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // falls always complete; a rise only happens while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      clk_q <= 1'b0;
    else if (at_edge) clk_q <= clk_q ? 1'b0 : run_i;
  end

  assign clk_o = clk_q;

  logic [LEN_W-1:0] hi_len_q, lo_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len_q <= '0;
      lo_len_q <= '0;
    end else begin
      hi_len_q <= clk_q ? ((hi_len_q == '1) ? hi_len_q : hi_len_q + 1'b1) : '0;
      lo_len_q <= !clk_q ? ((lo_len_q == '1) ? lo_len_q : lo_len_q + 1'b1) : '0;
    end
  end

  assert_full_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_q) |-> hi_len_q == LEN_W'(HALF));
  assert_min_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |-> lo_len_q >= LEN_W'(HALF));
  assert_no_rise_stopped_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_q && !run_i) |=> !clk_q);
endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl
  import strap_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             pwrdn_ni,
  input  logic [NPINS-1:0] pad_in_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic             sel_a_o,
  output logic             sel_b_o,
  output logic             spread_en_o
);
  pin_vec_t live_sync, held, cfg;
  logic     pd_sync_n, drv_en, run, div_clk;

  strap_sync #(.WIDTH(NPINS), .RST_VAL(1'b0)) u_pad_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(live_sync));

  strap_sync #(.WIDTH(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwrdn_ni), .q_o(pd_sync_n));

  strap_capture u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .pad_in_i(pad_in_i), .held_o(held), .drv_en_o(drv_en));

  assign run = drv_en & pd_sync_n;

  strap_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clk_o(div_clk));

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign pad_oe_o[p]  = drv_en;
    assign pad_out_o[p] = div_clk & drv_en;
  end

  assign cfg         = mode_i ? held : live_sync;
  assign sel_a_o     = cfg[PIN_SEL_A];
  assign sel_b_o     = cfg[PIN_SEL_B];
  assign spread_en_o = ~cfg[PIN_SS_N];

  assert_out_needs_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);
  assert_oe_all_or_none_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o == '0) || (pad_oe_o == '1));
  assert_strap_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pad_oe_o) != '0 && pad_oe_o != '0) |-> $stable({sel_a_o, sel_b_o, spread_en_o}));
endmodule

// File: tb/strap_pin_ctrl_tb.sv
module strap_pin_ctrl_tb_top;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode = 1'b0;
  logic pwrdn_n = 1'b1;
  logic [2:0] pad_in = '0;
  logic [2:0] pad_out, pad_oe;
  logic sel_a, sel_b, ss_en;

  int n_checks = 0;
  int n_fail = 0;
  int hi_run = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strap_pin_ctrl #(.CLK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .pwrdn_ni(pwrdn_n),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .sel_a_o(sel_a), .sel_b_o(sel_b), .spread_en_o(ss_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] cfg_of(input logic [2:0] v);
    return {~v[2], v[1], v[0]};
  endfunction

  // high-phase length monitor (R6/R7)
  always @(negedge clk) begin
    if (!rst_ni) hi_run <= 0;
    else if (pad_out[0]) hi_run <= hi_run + 1;
    else begin
      if (hi_run > 0) chk("R7 high phase length", hi_run, HALF);
      hi_run <= 0;
    end
  end

  task automatic do_reset(input logic m, input logic [2:0] v);
    @(negedge clk);
    rst_ni = 1'b0; mode = m; pad_in = v; pwrdn_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", pad_oe, 3'b000);
    chk("R1 out in reset", pad_out, 3'b000);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R5 oe after first edge", pad_oe, 3'b000);
    pad_in = ~v;
    @(negedge clk);
    chk("R5 oe after second edge", pad_oe, m ? 3'b111 : 3'b000);
  endtask

  initial begin
    // live-input mode sweep
    for (int v = 0; v < 8; v++) begin
      do_reset(1'b0, 3'(v));
      repeat (3) @(negedge clk);
      chk("R3 live settle", {ss_en, sel_b, sel_a}, cfg_of(~3'(v)));
      pad_in = 3'(v);
      @(negedge clk);
      chk("R3 one edge still old", {ss_en, sel_b, sel_a}, cfg_of(~3'(v)));
      @(negedge clk);
      chk("R3 two edges new", {ss_en, sel_b, sel_a}, cfg_of(3'(v)));
      repeat (3 * DIV) @(negedge clk);
      chk("R2 oe off in live mode", pad_oe, 3'b000);
      chk("R9 no drive without oe", pad_out, 3'b000);
    end
    // strap mode sweep
    for (int v = 0; v < 8; v++) begin
      int rises;
      logic prev;
      bit low_ok, seen;
      do_reset(1'b1, 3'(v));
      repeat (2 * DIV) @(negedge clk);
      chk("R4 strap held", {ss_en, sel_b, sel_a}, cfg_of(3'(v)));
      rises = 0; prev = pad_out[0];
      for (int c = 0; c < 8 * DIV; c++) begin
        @(negedge clk);
        if (pad_out[0] && !prev) rises++;
        prev = pad_out[0];
      end
      chk("R6 rises per window", rises, 8);
      chk("R9 all pins equal", pad_out, {3{pad_out[0]}});
      pwrdn_n = 1'b0;
      repeat (3 * DIV) @(negedge clk);
      low_ok = 1'b1;
      for (int c = 0; c < 2 * DIV; c++) begin
        @(negedge clk);
        if (pad_out != 3'b000) low_ok = 1'b0;
      end
      chk("R7 stopped low", low_ok, 1'b1);
      chk("R8 strap kept in power-down", {ss_en, sel_b, sel_a}, cfg_of(3'(v)));
      pwrdn_n = 1'b1;
      seen = 1'b0;
      for (int c = 0; c < 3 * DIV; c++) begin
        @(negedge clk);
        if (pad_out[0]) seen = 1'b1;
      end
      chk("R7 resumes", seen, 1'b1);
      chk("R8 no resample after release", {ss_en, sel_b, sel_a}, cfg_of(3'(v)));
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule